// File: doc/BRIEF.md
# NAND Page Hamming Code Generator

This block sits on the byte path of a NAND flash controller and builds a single-error-correcting parity code while page data streams through. Each 256-byte chunk of a page gets a 22-bit code. The code is made of two 11-bit words. The "set" word holds, for each address bit, the parity of every data bit whose address has that bit at 1. The "clear" word holds the same parity over the data bits whose address has that bit at 0. Software packs a chunk's code as `set | clear << 11`, stores it as three little-endian bytes, and later XORs the stored code with a freshly computed one. For a single flipped data bit, the low half of that difference is the bit's address and the high half is its complement.

The page size is either one chunk of 256 bytes, which yields one word pair, or two chunks of 512 bytes in total, which yields two word pairs. The page size is chosen when the accumulators are cleared, and a clear must be issued before every page. Bytes arrive on a valid/ready stream. The sink applies no back-pressure, except in the cycle in which a clear is requested. Bytes offered after the page is complete are accepted and discarded. A one-cycle done pulse marks the moment the last byte of the page has been absorbed. The results then hold until the next clear.

Top module: `nand_ecc_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released, all four code words are zero, `done` is low, `in_ready` is high, and the page size is 256 bytes.
- R2: The address of a data bit within a chunk is 11 bits: bits [2:0] are the bit position (0 = LSB) and bits [10:3] are the byte offset within the chunk. Bit k of a chunk's set word is the XOR of all accepted data bits whose address has bit k = 1. Bit k of its clear word is the XOR over the data bits whose address has bit k = 0.
- R3: With `page_sel` = 0 latched (256-byte pages), only pair 0 accumulates and pair 1 stays zero. Bytes after the 256th are ignored.
- R4: With `page_sel` = 1 latched (512-byte pages), bytes 0..255 feed pair 0 and bytes 256..511 feed pair 1. The byte offset restarts at 0 for the second chunk. Bytes after the 512th are ignored.
- R5: `ecc_clr` is synchronous. On the edge where it is high, all four words and the byte count go to zero and `page_sel` is latched as the page size.
- R6: `in_ready` is low exactly in cycles where `ecc_clr` is high, and a byte offered in such a cycle is dropped. In every other cycle `in_ready` is high. A byte is taken on an edge where both `in_valid` and `in_ready` are high.
- R7: `done` is high for exactly one cycle, in the cycle after the edge on which the last byte of the configured page is taken. Ignored surplus bytes do not raise it again.
- R8: A cycle with `in_valid` low leaves every code word unchanged. A completed page leaves every code word unchanged until the next clear.
- R9: Within each pair, set XOR clear is either all zeros or all ones, because every bit of it equals the parity of the whole chunk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ecc_clr | input | 1 | Synchronous clear of code words and byte count; latches page size |
| page_sel | input | 1 | Page size to latch on clear: 0 = 256 bytes, 1 = 512 bytes |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream ready; low only while `ecc_clr` is high |
| in_data | input | 8 | Stream byte |
| done | output | 1 | One-cycle pulse after the last page byte is taken |
| code0_set | output | 11 | Chunk 0 set-parity word |
| code0_clr | output | 11 | Chunk 0 clear-parity word |
| code1_set | output | 11 | Chunk 1 set-parity word |
| code1_clr | output | 11 | Chunk 1 clear-parity word |

## Verification
The case that is hardest to reach from the ports is the one the code exists for: a page that differs from a reference page in exactly one bit. The resulting word differences must then spell out that bit's address and its complement. The stimulus streams a random page and captures its code. It then clears, replays the identical page with one chosen bit flipped, and checks the word differences against the known address. This is done once in the first chunk and once in the second chunk of a 512-byte page. A clear raised in the same cycle as a valid byte, a clear in the middle of a page, and surplus bytes after completion are all driven explicitly. Idle gaps are scattered through every page.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  localparam int unsigned DATA_W     = 8;
  localparam int unsigned BIT_IDX_W  = $clog2(DATA_W);
  localparam int unsigned NUM_CHUNKS = 2;
  localparam int unsigned CHUNK_DEF  = 256;

  typedef enum logic {
    PG_SINGLE = 1'b0,
    PG_DOUBLE = 1'b1
  } page_mode_e;

  // Byte-lane mask: lanes whose bit position has bit k equal to want.
  function automatic logic [DATA_W-1:0] pos_mask(input int k, input logic want);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) begin
      m[i] = ((((i >> k) & 1) == 1) == want);
    end
    return m;
  endfunction

endpackage

// File: rtl/nand_ecc_byte_par.sv
module nand_ecc_byte_par
  import nand_ecc_pkg::*;
#(
  parameter int unsigned OFF_W = 8,
  localparam int unsigned PAR_W = BIT_IDX_W + OFF_W
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [PAR_W-1:0]  set_o,
  output logic [PAR_W-1:0]  clr_o
);

  logic byte_par;
  assign byte_par = ^data_i;

  for (genvar k = 0; k < PAR_W; k++) begin : g_bit
    if (k < BIT_IDX_W) begin : g_pos
      assign set_o[k] = ^(data_i & pos_mask(k, 1'b1));
      assign clr_o[k] = ^(data_i & pos_mask(k, 1'b0));
    end else begin : g_off
      assign set_o[k] = byte_par &  off_i[k-BIT_IDX_W];
      assign clr_o[k] = byte_par & ~off_i[k-BIT_IDX_W];
    end
  end

endmodule

// File: rtl/nand_ecc_acc.sv
module nand_ecc_acc #(
  parameter int unsigned PAR_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [PAR_W-1:0] set_in,
  input  logic [PAR_W-1:0] clr_in,
  output logic [PAR_W-1:0] set_q,
  output logic [PAR_W-1:0] clr_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q <= '0;
      clr_q <= '0;
    end else if (clr) begin
      set_q <= '0;
      clr_q <= '0;
    end else if (en) begin
      set_q <= set_q ^ set_in;
      clr_q <= clr_q ^ clr_in;
    end
  end

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (set_q == '0) && (clr_q == '0)); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en) |=> $stable(set_q) && $stable(clr_q)); // R8

  AST_PAIR_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_q ^ clr_q) == '0) || ((set_q ^ clr_q) == '1)); // R9

endmodule

// File: rtl/nand_ecc_ctrl.sv
module nand_ecc_ctrl
  import nand_ecc_pkg::*;
#(
  parameter int unsigned CHUNK_BYTES = 256,
  localparam int unsigned OFF_W = $clog2(CHUNK_BYTES),
  localparam int unsigned SEL_W = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1,
  localparam int unsigned CNT_W = $clog2(NUM_CHUNKS * CHUNK_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ecc_clr,
  input  logic             page_sel,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             accept,
  output logic [SEL_W-1:0] chunk_sel,
  output logic [OFF_W-1:0] byte_off,
  output logic             page_full,
  output logic             two_chunk,
  output logic             done
);

  localparam logic [CNT_W-1:0] LIM_ONE = CNT_W'(CHUNK_BYTES);
  localparam logic [CNT_W-1:0] LIM_TWO = CNT_W'(NUM_CHUNKS * CHUNK_BYTES);

  page_mode_e       mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             done_q;

  assign limit     = (mode_q == PG_DOUBLE) ? LIM_TWO : LIM_ONE;
  assign in_ready  = ~ecc_clr;
  assign page_full = (cnt_q >= limit);
  assign accept    = in_valid & in_ready & ~page_full;
  assign byte_off  = cnt_q[OFF_W-1:0];
  assign chunk_sel = cnt_q[OFF_W +: SEL_W];
  assign two_chunk = (mode_q == PG_DOUBLE);
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      mode_q <= PG_SINGLE;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (ecc_clr) begin
        cnt_q  <= '0;
        mode_q <= page_sel ? PG_DOUBLE : PG_SINGLE;
      end else if (accept) begin
        cnt_q  <= cnt_q + 1'b1;
        done_q <= (cnt_q == limit - 1'b1);
      end
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R7

  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (cnt_q == limit)); // R7

  AST_CLEAR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_clr |=> (cnt_q == '0) && !done_q); // R5

endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
  import nand_ecc_pkg::*;
#(
  parameter int unsigned CHUNK_BYTES = CHUNK_DEF,
  localparam int unsigned OFF_W = $clog2(CHUNK_BYTES),
  localparam int unsigned PAR_W = BIT_IDX_W + OFF_W,
  localparam int unsigned SEL_W = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ecc_clr,
  input  logic              page_sel,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              done,
  output logic [PAR_W-1:0]  code0_set,
  output logic [PAR_W-1:0]  code0_clr,
  output logic [PAR_W-1:0]  code1_set,
  output logic [PAR_W-1:0]  code1_clr
);

  logic             accept;
  logic [SEL_W-1:0] chunk_sel;
  logic [OFF_W-1:0] byte_off;
  logic             page_full;
  logic             two_chunk;
  logic [PAR_W-1:0] set_bit;
  logic [PAR_W-1:0] clr_bit;
  logic [PAR_W-1:0] set_w [NUM_CHUNKS];
  logic [PAR_W-1:0] clr_w [NUM_CHUNKS];

  nand_ecc_ctrl #(.CHUNK_BYTES(CHUNK_BYTES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ecc_clr   (ecc_clr),
    .page_sel  (page_sel),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .accept    (accept),
    .chunk_sel (chunk_sel),
    .byte_off  (byte_off),
    .page_full (page_full),
    .two_chunk (two_chunk),
    .done      (done)
  );

  nand_ecc_byte_par #(.OFF_W(OFF_W)) u_par (
    .data_i (in_data),
    .off_i  (byte_off),
    .set_o  (set_bit),
    .clr_o  (clr_bit)
  );

  for (genvar c = 0; c < NUM_CHUNKS; c++) begin : g_chunk
    logic en_c;
    assign en_c = accept & (chunk_sel == SEL_W'(c));

    nand_ecc_acc #(.PAR_W(PAR_W)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (ecc_clr),
      .en     (en_c),
      .set_in (set_bit),
      .clr_in (clr_bit),
      .set_q  (set_w[c]),
      .clr_q  (clr_w[c])
    );
  end

  assign code0_set = set_w[0];
  assign code0_clr = clr_w[0];
  assign code1_set = set_w[1];
  assign code1_clr = clr_w[1];

  AST_UPPER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !two_chunk |-> (code1_set == '0) && (code1_clr == '0)); // R3

  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (page_full && !ecc_clr) |=> $stable(code0_set) && $stable(code0_clr)
                                && $stable(code1_set) && $stable(code1_clr)); // R8

  AST_DONE_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_valid) && !$past(ecc_clr)); // R7

endmodule

// File: tb/nand_ecc_gen_tb.sv
module nand_ecc_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ecc_clr = 1'b0;
  logic        page_sel = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = 8'h00;
  logic        done;
  logic [10:0] code0_set, code0_clr, code1_set, code1_clr;

  int tests = 0;
  int fails = 0;
  int done_seen = 0;
  bit finished = 1'b0;

  logic [7:0] page_buf [512];

  logic [10:0] m_set [2];
  logic [10:0] m_clr [2];
  int          m_cnt = 0;
  bit          m_p512 = 1'b0;
  bit          m_done = 1'b0;

  always #5 clk = ~clk;

  nand_ecc_gen u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ecc_clr   (ecc_clr),
    .page_sel  (page_sel),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .done      (done),
    .code0_set (code0_set),
    .code0_clr (code0_clr),
    .code1_set (code1_set),
    .code1_clr (code1_clr)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int c = 0; c < 2; c++) begin
      m_set[c] = '0;
      m_clr[c] = '0;
    end
    m_cnt = 0;
  endtask

  // Behavioural reference, evaluated on the same edge as the design.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_clear();
      m_p512 = 1'b0;
      m_done = 1'b0;
    end else begin
      m_done = 1'b0;
      if (ecc_clr) begin
        model_clear();
        m_p512 = page_sel;
      end else if (in_valid && m_cnt < (m_p512 ? 512 : 256)) begin
        for (int i = 0; i < 8; i++) begin
          if (in_data[i]) begin
            int addr;
            addr = (m_cnt % 256) * 8 + i;
            for (int k = 0; k < 11; k++) begin
              if (((addr >> k) & 1) == 1) m_set[m_cnt / 256][k] = ~m_set[m_cnt / 256][k];
              else                        m_clr[m_cnt / 256][k] = ~m_clr[m_cnt / 256][k];
            end
          end
        end
        m_cnt++;
        if (m_cnt == (m_p512 ? 512 : 256)) m_done = 1'b1;
      end
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(code0_set == m_set[0] && code0_clr == m_clr[0], "R2 pair0",
            {10'd0, code0_set, code0_clr}, {10'd0, m_set[0], m_clr[0]});
      check(code1_set == m_set[1] && code1_clr == m_clr[1], "R4 pair1",
            {10'd0, code1_set, code1_clr}, {10'd0, m_set[1], m_clr[1]});
      check(done == m_done, "R7 done", 32'(done), 32'(m_done));
      check(in_ready == !ecc_clr, "R6 ready", 32'(in_ready), 32'(!ecc_clr));
      if (done) done_seen++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic tick(input logic clr, input logic sel, input logic v, input logic [7:0] d);
    @(negedge clk);
    #1;
    ecc_clr  = clr;
    page_sel = sel;
    in_valid = v;
    in_data  = d;
  endtask

  task automatic idle();
    tick(1'b0, page_sel, 1'b0, 8'h00);
  endtask

  task automatic clear_page(input logic sel);
    tick(1'b1, sel, 1'b0, 8'h00);
  endtask

  task automatic stream(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom % 4) == 0) tick(1'b0, page_sel, 1'b0, $urandom);
      tick(1'b0, page_sel, 1'b1, page_buf[i]);
    end
    idle();
    idle();
  endtask

  task automatic fill_random();
    for (int i = 0; i < 512; i++) page_buf[i] = 8'($urandom);
  endtask

  initial begin
    logic [10:0] ref_s0, ref_c0, ref_s1, ref_c1;
    int d0;

    // R1: reset state
    #2;
    check(in_ready == 1'b1, "R1 ready in reset", 32'(in_ready), 1);
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk); #2;
    check({code0_set, code0_clr, code1_set, code1_clr} == '0, "R1 words zero",
          {code0_set, code0_clr, code1_set, code1_clr}, 0);
    check(done == 1'b0, "R1 done low", 32'(done), 0);

    // R2: single set bit at address 0 gives set word 0, clear word all ones
    clear_page(1'b0);
    for (int i = 0; i < 256; i++) page_buf[i] = 8'h00;
    page_buf[0] = 8'h01;
    stream(256, 1'b0);
    check(code0_set == 11'h000 && code0_clr == 11'h7FF, "R2 lone bit",
          {code0_set, code0_clr}, {11'h000, 11'h7FF});

    // R3, R7: random 256-byte page with gaps and surplus bytes
    d0 = done_seen;
    clear_page(1'b0);
    fill_random();
    stream(256, 1'b1);
    stream(6, 1'b0);
    check(done_seen - d0 == 1, "R7 one pulse per page", done_seen - d0, 1);
    check(code1_set == '0 && code1_clr == '0, "R3 pair1 idle",
          {code1_set, code1_clr}, 0);
    check((code0_set ^ code0_clr) == '0 || (code0_set ^ code0_clr) == '1,
          "R9 balance", code0_set ^ code0_clr, 0);

    // R2: one-bit flip in chunk 0 reveals address 37*8+5
    clear_page(1'b0);
    stream(256, 1'b0);
    ref_s0 = code0_set; ref_c0 = code0_clr;
    page_buf[37] ^= 8'h20;
    clear_page(1'b0);
    stream(256, 1'b1);
    check((code0_set ^ ref_s0) == 11'd301, "R2 syndrome set", code0_set ^ ref_s0, 301);
    check((code0_clr ^ ref_c0) == (11'h7FF ^ 11'd301), "R2 syndrome clear",
          code0_clr ^ ref_c0, 11'h7FF ^ 11'd301);

    // R4: 512-byte page, flip in chunk 1
    d0 = done_seen;
    clear_page(1'b1);
    fill_random();
    stream(512, 1'b1);
    check(done_seen - d0 == 1, "R7 one pulse 512", done_seen - d0, 1);
    ref_s0 = code0_set; ref_c0 = code0_clr;
    ref_s1 = code1_set; ref_c1 = code1_clr;
    page_buf[256 + 37] ^= 8'h20;
    clear_page(1'b1);
    stream(512, 1'b0);
    stream(4, 1'b0);
    check(code0_set == ref_s0 && code0_clr == ref_c0, "R4 pair0 unchanged",
          {code0_set, code0_clr}, {ref_s0, ref_c0});
    check((code1_set ^ ref_s1) == 11'd301, "R4 syndrome set", code1_set ^ ref_s1, 301);
    check((code1_clr ^ ref_c1) == (11'h7FF ^ 11'd301), "R4 syndrome clear",
          code1_clr ^ ref_c1, 11'h7FF ^ 11'd301);

    // R8: idle cycles after a full page change nothing
    ref_s1 = code1_set;
    repeat (5) idle();
    check(code1_set == ref_s1, "R8 hold", code1_set, ref_s1);

    // R5, R6: clear with a valid byte in the same cycle drops the byte
    tick(1'b1, 1'b0, 1'b1, 8'hFF);
    idle();
    check({code0_set, code0_clr, code1_set, code1_clr} == '0, "R6 byte dropped on clear",
          {code0_set, code0_clr, code1_set, code1_clr}, 0);

    // R5: clear mid-page restarts counting at offset zero
    fill_random();
    stream(100, 1'b1);
    clear_page(1'b0);
    page_buf[0] = 8'h01;
    stream(1, 1'b0);
    check(code0_set == 11'h000 && code0_clr == 11'h7FF, "R5 restart",
          {code0_set, code0_clr}, {11'h000, 11'h7FF});

    repeat (3) idle();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule